// File: doc/BRIEF.md
# Deblocking Edge Order Sequencer

This block sets the pace for one macroblock in an in-loop deblocking filter. A single pulse on `start_i` launches a fixed schedule. On every clock cycle the block tells the filter datapath whether it is working on a real 4x4 sub-block or an idle slot. It also gives the plane and raster index of that sub-block and the edge direction. It drives the read and write strobes for the current-macroblock buffer, the left-neighbour buffer and the upper-neighbour buffer. Pixel arithmetic, boundary-strength logic and the memories themselves sit outside this block. The plane and sub-block index act as the buffer address.

The schedule has four phases. The first is a setup phase. A vertical-edge pass follows, covering every luma and chroma sub-block, and then a horizontal-edge pass in the same slot order. Last comes an optional stall phase. Each pass has one idle slot in front of every luma row except the first, and that slot is used to bring in the left neighbour. The stall phase grows when the macroblock lies on the bottom row of the frame, and again when it is the last macroblock of the frame. Its length is set by flags that are sampled together with the start pulse.

Top module: `dbf_edge_seq`

## Requirements
- R1: After reset, and whenever idle, `busy_o`, `done_o`, `valid_o`, `dir_o`, `plane_o`, `blk_o` and all six buffer strobes are 0.
- R2: A `start_i` seen at a clock edge while idle raises `busy_o` from the next cycle. The first 10 busy cycles are setup cycles with `valid_o`, `dir_o` and all strobes at 0.
- R3: The vertical pass (`dir_o`=0) follows setup directly and has 27 slots. Luma sub-blocks 0..3 come first. Each later luma row is an idle slot followed by that row's four sub-blocks. After the luma rows come Cb 0..3 and then Cr 0..3. The plane code is 0 for luma, 1 for Cb and 2 for Cr. The sub-block index is raster order within the plane: 0..15 for luma on a 4-wide grid, 0..3 for chroma on a 2-wide grid.
- R4: The horizontal pass (`dir_o`=1) follows the vertical pass directly and uses the same 27-slot order.
- R5: Every slot lasts 4 cycles. `valid_o` is 1 for all four cycles of a sub-block slot and 0 in an idle slot. `plane_o` and `blk_o` hold the slot's values and are 0 whenever `valid_o` is 0.
- R6: `cur_rd_o` pulses in cycle 0 of every sub-block slot and `cur_wr_o` pulses in cycle 3 of it, in both passes.
- R7: `left_rd_o` pulses in cycle 0 of each idle slot of the vertical pass. `left_wr_o` pulses in cycle 3 of vertical sub-block slots in the rightmost column (luma index mod 4 = 3, chroma index mod 2 = 1).
- R8: `up_rd_o` pulses in cycle 0 of horizontal sub-block slots in the top row (luma index < 4, chroma index < 2). `up_wr_o` pulses in cycle 3 of horizontal slots in the bottom row (luma index >= 12, chroma index >= 2).
- R9: `busy_o` stays high for 226 cycles. Add 20 when `last_row_i` was 1 at the accepted start and 12 when `last_mb_i` was 1 then. The extra stall cycles come after the horizontal pass, with `valid_o`, `dir_o` and all strobes at 0.
- R10: `done_o` is high for exactly one cycle, the one right after the last busy cycle, and `busy_o` is 0 in that cycle.
- R11: While busy, `start_i`, `last_row_i` and `last_mb_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches one macroblock when idle |
| last_row_i | input | 1 | Macroblock is on the bottom frame row (sampled with start) |
| last_mb_i | input | 1 | Macroblock is the final one of the frame (sampled with start) |
| busy_o | output | 1 | Schedule in progress |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | Current slot carries a sub-block |
| dir_o | output | 1 | 0 vertical edges, 1 horizontal edges |
| plane_o | output | 2 | 0 luma, 1 Cb, 2 Cr |
| blk_o | output | 4 | Raster sub-block index within the plane |
| cur_rd_o | output | 1 | Current-buffer read strobe |
| cur_wr_o | output | 1 | Current-buffer write strobe |
| left_rd_o | output | 1 | Left-neighbour read strobe |
| left_wr_o | output | 1 | Left-neighbour write strobe |
| up_rd_o | output | 1 | Upper-neighbour read strobe |
| up_wr_o | output | 1 | Upper-neighbour write strobe |

## Verification
Some relations are checked on every cycle. Strobes only fire inside a sub-block slot of the correct direction, a left-neighbour fetch only happens in a vertical idle slot, and the plane and index hold steady across a slot after its read. `done_o` and `busy_o` never overlap, a falling `busy_o` always brings `done_o`, and a start seen while busy never ends the run early. The exact slot order, the per-column and per-row strobe choice, the 226/246/238/258 cycle totals and the fact that the flags are ignored after launch can only be shown by the bench's scenarios. The bench compares every output in every cycle against a schedule it builds on its own.

// File: rtl/dbf_seq_pkg.sv
package dbf_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_INIT = 3'd1,
    ST_VERT = 3'd2,
    ST_HORZ = 3'd3,
    ST_TAIL = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    PL_LUMA = 2'd0,
    PL_CB   = 2'd1,
    PL_CR   = 2'd2
  } plane_e;
endpackage

// File: rtl/dbf_slot_map.sv
module dbf_slot_map
  import dbf_seq_pkg::*;
#(
  parameter int LUMA_DIM   = 4,
  parameter int CHROMA_DIM = 2,
  parameter int SLOT_W     = 5,
  parameter int BLK_W      = 4
) (
  input  logic [SLOT_W-1:0] slot_i,
  output logic              data_o,
  output plane_e            plane_o,
  output logic [BLK_W-1:0]  blk_o
);
  localparam int ROW_GRP   = LUMA_DIM + 1;
  localparam int LUMA_SPAN = LUMA_DIM + (LUMA_DIM - 1) * ROW_GRP;
  localparam int CHR_BLKS  = CHROMA_DIM * CHROMA_DIM;

  always_comb begin
    int s, t, g, p;
    s       = int'(slot_i);
    t       = 0;
    g       = 0;
    p       = 0;
    data_o  = 1'b0;
    plane_o = PL_LUMA;
    blk_o   = '0;
    if (s < LUMA_DIM) begin
      data_o = 1'b1;
      blk_o  = BLK_W'(s);
    end else if (s < LUMA_SPAN) begin
      // each later luma row: one idle slot, then the row's sub-blocks
      t = s - LUMA_DIM;
      g = t / ROW_GRP;
      p = t % ROW_GRP;
      if (p != 0) begin
        data_o = 1'b1;
        blk_o  = BLK_W'((g + 1) * LUMA_DIM + p - 1);
      end
    end else if (s < LUMA_SPAN + CHR_BLKS) begin
      data_o  = 1'b1;
      plane_o = PL_CB;
      blk_o   = BLK_W'(s - LUMA_SPAN);
    end else begin
      data_o  = 1'b1;
      plane_o = PL_CR;
      blk_o   = BLK_W'(s - LUMA_SPAN - CHR_BLKS);
    end
  end
endmodule

// File: rtl/dbf_buf_en.sv
module dbf_buf_en
  import dbf_seq_pkg::*;
#(
  parameter int LUMA_DIM   = 4,
  parameter int CHROMA_DIM = 2,
  parameter int BLK_W      = 4
) (
  input  logic             in_pass_i,
  input  logic             dir_i,
  input  logic             data_i,
  input  logic             first_cyc_i,
  input  logic             last_cyc_i,
  input  plane_e           plane_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             cur_rd_o,
  output logic             cur_wr_o,
  output logic             left_rd_o,
  output logic             left_wr_o,
  output logic             up_rd_o,
  output logic             up_wr_o
);
  logic right_col, top_row, bottom_row;

  always_comb begin
    int b, dim;
    b          = int'(blk_i);
    dim        = (plane_i == PL_LUMA) ? LUMA_DIM : CHROMA_DIM;
    right_col  = (b % dim) == dim - 1;
    top_row    = (b / dim) == 0;
    bottom_row = (b / dim) == dim - 1;
  end

  always_comb begin
    logic act;
    act       = in_pass_i && data_i;
    cur_rd_o  = act && first_cyc_i;
    cur_wr_o  = act && last_cyc_i;
    left_rd_o = in_pass_i && !dir_i && !data_i && first_cyc_i;
    left_wr_o = act && !dir_i && last_cyc_i && right_col;
    up_rd_o   = act && dir_i && first_cyc_i && top_row;
    up_wr_o   = act && dir_i && last_cyc_i && bottom_row;
  end
endmodule

// File: rtl/dbf_seq_ctrl.sv
module dbf_seq_ctrl
  import dbf_seq_pkg::*;
#(
  parameter int INIT_CYC      = 10,
  parameter int SLOT_CYC      = 4,
  parameter int SLOTS         = 27,
  parameter int ROW_EXTRA_CYC = 20,
  parameter int MB_EXTRA_CYC  = 12,
  parameter int SLOT_W        = 5,
  parameter int CYC_W         = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              last_row_i,
  input  logic              last_mb_i,
  output seq_state_e        state_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [CYC_W-1:0]  cyc_o,
  output logic              done_o
);
  localparam int TAIL_MAX = ROW_EXTRA_CYC + MB_EXTRA_CYC;
  localparam int CNT_MAX  = (TAIL_MAX > INIT_CYC) ? TAIL_MAX : INIT_CYC;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0]  INIT_LAST = CNT_W'(INIT_CYC - 1);
  localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(SLOT_CYC - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, tail_len;
  logic             lr_q, lm_q;

  always_comb begin
    tail_len = '0;
    if (lr_q) tail_len = tail_len + CNT_W'(ROW_EXTRA_CYC);
    if (lm_q) tail_len = tail_len + CNT_W'(MB_EXTRA_CYC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      slot_o  <= '0;
      cyc_o   <= '0;
      done_o  <= 1'b0;
      lr_q    <= 1'b0;
      lm_q    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_INIT;
            cnt_q   <= '0;
            lr_q    <= last_row_i;
            lm_q    <= last_mb_i;
          end
        end
        ST_INIT: begin
          if (cnt_q == INIT_LAST) begin
            state_q <= ST_VERT;
            cnt_q   <= '0;
            slot_o  <= '0;
            cyc_o   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_VERT, ST_HORZ: begin
          if (cyc_o == CYC_LAST) begin
            cyc_o <= '0;
            if (slot_o == SLOT_LAST) begin
              slot_o <= '0;
              if (state_q == ST_VERT) begin
                state_q <= ST_HORZ;
              end else if (tail_len == '0) begin
                state_q <= ST_IDLE;
                done_o  <= 1'b1;
              end else begin
                state_q <= ST_TAIL;
                cnt_q   <= '0;
              end
            end else begin
              slot_o <= slot_o + 1'b1;
            end
          end else begin
            cyc_o <= cyc_o + 1'b1;
          end
        end
        ST_TAIL: begin
          if (cnt_q == tail_len - 1'b1) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_o  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/dbf_edge_seq.sv
module dbf_edge_seq
  import dbf_seq_pkg::*;
#(
  parameter int LUMA_DIM        = 4,
  parameter int CHROMA_DIM      = 2,
  parameter int INIT_CYC        = 10,
  parameter int SLOT_CYC        = 4,
  parameter int ROW_EXTRA_SLOTS = 5,
  parameter int MB_EXTRA_CYC    = 12
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 start_i,
  input  logic                                 last_row_i,
  input  logic                                 last_mb_i,
  output logic                                 busy_o,
  output logic                                 done_o,
  output logic                                 valid_o,
  output logic                                 dir_o,
  output logic [1:0]                           plane_o,
  output logic [$clog2(LUMA_DIM*LUMA_DIM)-1:0] blk_o,
  output logic                                 cur_rd_o,
  output logic                                 cur_wr_o,
  output logic                                 left_rd_o,
  output logic                                 left_wr_o,
  output logic                                 up_rd_o,
  output logic                                 up_wr_o
);
  localparam int BLK_W    = $clog2(LUMA_DIM * LUMA_DIM);
  localparam int CHR_BLKS = CHROMA_DIM * CHROMA_DIM;
  localparam int SLOTS    = LUMA_DIM * LUMA_DIM + 2 * CHR_BLKS + LUMA_DIM - 1;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int CYC_W    = $clog2(SLOT_CYC);

  seq_state_e        state;
  logic [SLOT_W-1:0] slot;
  logic [CYC_W-1:0]  cyc;
  logic              data, in_pass;
  plane_e            map_plane;
  logic [BLK_W-1:0]  map_blk;

  dbf_seq_ctrl #(
    .INIT_CYC     (INIT_CYC),
    .SLOT_CYC     (SLOT_CYC),
    .SLOTS        (SLOTS),
    .ROW_EXTRA_CYC(ROW_EXTRA_SLOTS * SLOT_CYC),
    .MB_EXTRA_CYC (MB_EXTRA_CYC),
    .SLOT_W       (SLOT_W),
    .CYC_W        (CYC_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .last_row_i(last_row_i),
    .last_mb_i (last_mb_i),
    .state_o   (state),
    .slot_o    (slot),
    .cyc_o     (cyc),
    .done_o    (done_o)
  );

  dbf_slot_map #(
    .LUMA_DIM  (LUMA_DIM),
    .CHROMA_DIM(CHROMA_DIM),
    .SLOT_W    (SLOT_W),
    .BLK_W     (BLK_W)
  ) u_map (
    .slot_i (slot),
    .data_o (data),
    .plane_o(map_plane),
    .blk_o  (map_blk)
  );

  assign in_pass = (state == ST_VERT) || (state == ST_HORZ);
  assign busy_o  = state != ST_IDLE;
  assign dir_o   = state == ST_HORZ;
  assign valid_o = in_pass && data;
  assign plane_o = valid_o ? map_plane : PL_LUMA;
  assign blk_o   = valid_o ? map_blk : '0;

  dbf_buf_en #(
    .LUMA_DIM  (LUMA_DIM),
    .CHROMA_DIM(CHROMA_DIM),
    .BLK_W     (BLK_W)
  ) u_en (
    .in_pass_i  (in_pass),
    .dir_i      (dir_o),
    .data_i     (data),
    .first_cyc_i(cyc == '0),
    .last_cyc_i (cyc == CYC_W'(SLOT_CYC - 1)),
    .plane_i    (map_plane),
    .blk_i      (map_blk),
    .cur_rd_o   (cur_rd_o),
    .cur_wr_o   (cur_wr_o),
    .left_rd_o  (left_rd_o),
    .left_wr_o  (left_wr_o),
    .up_rd_o    (up_rd_o),
    .up_wr_o    (up_wr_o)
  );
endmodule

// File: rtl/dbf_edge_seq_chk.sv
module dbf_edge_seq_chk #(
  parameter int BLK_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             valid_o,
  input logic             dir_o,
  input logic [1:0]       plane_o,
  input logic [BLK_W-1:0] blk_o,
  input logic             cur_rd_o,
  input logic             cur_wr_o,
  input logic             left_rd_o,
  input logic             left_wr_o,
  input logic             up_rd_o,
  input logic             up_wr_o
);
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_done_on_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_setup_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!valid_o && !cur_rd_o && !left_rd_o));

  assert_plane_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (plane_o != 2'd3));

  assert_slot_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_rd_o |=> (valid_o && $stable(plane_o) && $stable(blk_o) && !cur_rd_o && !cur_wr_o));

  assert_cur_in_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_rd_o || cur_wr_o) |-> (valid_o && busy_o));

  assert_left_rd_bubble_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_rd_o |-> (busy_o && !valid_o && !dir_o));

  assert_left_wr_vert_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_wr_o |-> (cur_wr_o && !dir_o));

  assert_up_horz_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_rd_o || up_wr_o) |-> (dir_o && valid_o));

  assert_start_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind dbf_edge_seq dbf_edge_seq_chk #(.BLK_W($clog2(LUMA_DIM*LUMA_DIM))) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .valid_o  (valid_o),
  .dir_o    (dir_o),
  .plane_o  (plane_o),
  .blk_o    (blk_o),
  .cur_rd_o (cur_rd_o),
  .cur_wr_o (cur_wr_o),
  .left_rd_o(left_rd_o),
  .left_wr_o(left_wr_o),
  .up_rd_o  (up_rd_o),
  .up_wr_o  (up_wr_o)
);

// File: tb/dbf_edge_seq_bench.sv
module dbf_edge_seq_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, last_row_i = 1'b0, last_mb_i = 1'b0;
  logic busy_o, done_o, valid_o, dir_o;
  logic [1:0] plane_o;
  logic [3:0] blk_o;
  logic cur_rd_o, cur_wr_o, left_rd_o, left_wr_o, up_rd_o, up_wr_o;

  int n_chk = 0, n_fail = 0;

  // expected slot table, built by walking rows and columns
  int t_data[27], t_plane[27], t_blk[27], t_right[27], t_top[27], t_bot[27];

  always #10 clk_i = ~clk_i;

  dbf_edge_seq u_dbf_edge_seq (
    .clk_i, .rst_ni, .start_i, .last_row_i, .last_mb_i,
    .busy_o, .done_o, .valid_o, .dir_o, .plane_o, .blk_o,
    .cur_rd_o, .cur_wr_o, .left_rd_o, .left_wr_o, .up_rd_o, .up_wr_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(inout int n, input int d, input int pl, input int b,
                      input int r, input int tp, input int bt);
    t_data[n] = d; t_plane[n] = pl; t_blk[n] = b;
    t_right[n] = r; t_top[n] = tp; t_bot[n] = bt;
    n++;
  endtask

  task automatic build_table();
    int n = 0;
    for (int y = 0; y < 4; y++) begin
      if (y > 0) push(n, 0, 0, 0, 0, 0, 0);
      for (int x = 0; x < 4; x++)
        push(n, 1, 0, y * 4 + x, int'(x == 3), int'(y == 0), int'(y == 3));
    end
    for (int pl = 1; pl <= 2; pl++)
      for (int y = 0; y < 2; y++)
        for (int x = 0; x < 2; x++)
          push(n, 1, pl, y * 2 + x, int'(x == 1), int'(y == 0), int'(y == 1));
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " busy"}, busy_o, 0);
    chk({tag, " done"}, done_o, 0);
    chk({tag, " valid/dir"}, {valid_o, dir_o}, 0);
    chk({tag, " plane/blk"}, {plane_o, blk_o}, 0);
    chk({tag, " strobes"}, {cur_rd_o, cur_wr_o, left_rd_o, left_wr_o, up_rd_o, up_wr_o}, 0);
  endtask

  task automatic run_mb(input bit lr, input bit lm, input bit noise);
    int total;
    total = 226 + (lr ? 20 : 0) + (lm ? 12 : 0);
    @(negedge clk_i);
    start_i = 1'b1; last_row_i = lr; last_mb_i = lm;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < total; k++) begin
      int e_valid, e_dir, e_plane, e_blk, e_crd, e_cwr, e_lrd, e_lwr, e_urd, e_uwr;
      string tg;
      e_valid = 0; e_dir = 0; e_plane = 0; e_blk = 0;
      e_crd = 0; e_cwr = 0; e_lrd = 0; e_lwr = 0; e_urd = 0; e_uwr = 0;
      if (k < 10) begin
        tg = "R2";
      end else if (k < 226) begin
        int k2, w, s, c;
        k2 = k - 10; e_dir = k2 / 108; w = k2 % 108; s = w / 4; c = w % 4;
        tg = e_dir ? "R4" : "R3";
        e_valid = t_data[s];
        if (e_valid != 0) begin
          e_plane = t_plane[s]; e_blk = t_blk[s];
        end
        e_crd = int'(e_valid != 0 && c == 0);
        e_cwr = int'(e_valid != 0 && c == 3);
        e_lrd = int'(e_dir == 0 && e_valid == 0 && c == 0);
        e_lwr = int'(e_dir == 0 && e_valid != 0 && c == 3 && t_right[s] != 0);
        e_urd = int'(e_dir == 1 && e_valid != 0 && c == 0 && t_top[s] != 0);
        e_uwr = int'(e_dir == 1 && e_valid != 0 && c == 3 && t_bot[s] != 0);
      end else begin
        tg = "R9 stall";
      end
      chk($sformatf("R9 busy k=%0d", k), busy_o, 1);
      chk($sformatf("R10 done k=%0d", k), done_o, 0);
      chk($sformatf("%s dir k=%0d", tg, k), dir_o, e_dir);
      chk($sformatf("R5 valid k=%0d", k), valid_o, e_valid);
      chk($sformatf("%s plane/blk k=%0d", tg, k), {plane_o, blk_o}, e_plane * 16 + e_blk);
      chk($sformatf("R6 cur k=%0d", k), {cur_rd_o, cur_wr_o}, e_crd * 2 + e_cwr);
      chk($sformatf("R7 left k=%0d", k), {left_rd_o, left_wr_o}, e_lrd * 2 + e_lwr);
      chk($sformatf("R8 up k=%0d", k), {up_rd_o, up_wr_o}, e_urd * 2 + e_uwr);
      // R11: disturb inputs while busy, except at the last busy cycle's edge
      if (noise && k < total - 1) begin
        start_i = 1'($urandom_range(0, 1));
        last_row_i = 1'($urandom_range(0, 1));
        last_mb_i = 1'($urandom_range(0, 1));
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk("R10 done pulse", done_o, 1);
    chk("R10 busy low with done", busy_o, 0);
    @(negedge clk_i);
    check_idle("R10 after done R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd2024);
    build_table();
    repeat (3) @(negedge clk_i);
    check_idle("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R1 idle");
    run_mb(1'b0, 1'b0, 1'b0);
    run_mb(1'b1, 1'b0, 1'b0);
    run_mb(1'b0, 1'b1, 1'b0);
    run_mb(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) begin
      bit lr, lm;
      lr = 1'($urandom_range(0, 1));
      lm = 1'($urandom_range(0, 1));
      repeat ($urandom_range(0, 3)) @(negedge clk_i);
      run_mb(lr, lm, 1'b1);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule